// File: doc/BRIEF.md
# Predicated four-way deinterleaving load engine

The engine carries out one predicated structure load. Memory holds structures of four consecutive 32-bit words. Word `r` of structure `e` belongs in element `e` of the `r`-th destination vector register. The engine walks the structures from a start address, fetching words one at a time over a single-word read port that uses a request/valid handshake. It sorts each word into one of four internal vector buffers. When the whole walk is finished, it writes the four vectors to the register file on consecutive cycles and pulses done.

A byte-granular predicate controls the walk. Bit `4*e` of the predicate enables structure `e`. A disabled structure issues no reads, but the address still moves past its four words, and its element is written as zero in all four destinations. When the base value comes from the stack pointer, the base must be 16-byte aligned. A failed check, or a fault reported by memory, ends the operation with a fault flag and leaves the register file untouched. The vector length is a parameter.

Top module: `deint4_load`

## Requirements
- R1: While reset is asserted, including when reset arrives in the middle of an operation, and in the first cycle after reset, `mem_req_o`, `rf_we_o`, `done_o` and `fault_o` are all low.
- R2: The first word address is `base_i + (index_i << 2)`, computed modulo 2^64.
- R3: Word slot `k` (for k = 0 .. 4*VLEN/32-1) is at the first address plus 4*k. Reads are issued in ascending slot order. After a word is accepted, the next request on the following cycle is at the previous address plus 4.
- R4: The word in slot `k` lands in bits `[32*(k/4) +: 32]` of the vector written to register `(dst_i + k%4) mod 32`.
- R5: When predicate bit `4*e` is 0, no request is made for any of the four words of structure `e`, and element `e` of all four written vectors is zero.
- R6: Only predicate bits at positions that are multiples of 4 have any effect. All other predicate bits are ignored.
- R7: The destination register numbers are `dst_i`, `dst_i+1`, `dst_i+2` and `dst_i+3`, each taken modulo 32, so numbering wraps from 31 to 0.
- R8: The four register writes happen only after every slot has finished. They occur on four consecutive cycles in the order `dst_i` to `dst_i+3`, no read request overlaps them, and `done_o` pulses for one cycle on the cycle after the last write.
- R9: When `base_is_sp_i` is 1, at least one structure is enabled, and `base_i[3:0]` is nonzero, the engine issues no reads and no writes, and raises `done_o` together with `fault_o` on the cycle after start.
- R10: When no structure is enabled, a misaligned stack-pointer base faults only if `sp_chk_none_i` is 1. Otherwise the operation completes and writes four all-zero vectors.
- R11: When `mem_fault_i` is high while a request is pending, the engine stops making requests, makes no register writes, and raises `done_o` and `fault_o` on the next cycle.
- R12: A start pulse that arrives while an operation is running is ignored, and the running operation produces exactly the results it would have produced without it.
- R13: A pending request keeps `mem_req_o` high and `mem_addr_o` stable until `mem_rvalid_i` or `mem_fault_i` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts an operation when the engine is idle |
| base_i | input | 64 | Base byte address |
| index_i | input | 64 | Word index, scaled by 4 |
| base_is_sp_i | input | 1 | Base comes from the stack pointer, so the alignment check applies |
| pred_i | input | VLEN/8 | Byte-granular predicate; bit 4*e enables structure e |
| dst_i | input | 5 | First destination register number |
| sp_chk_none_i | input | 1 | Apply the alignment check even when no structure is enabled |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 64 | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid; accepts the pending request |
| mem_rdata_i | input | 32 | Read data word |
| mem_fault_i | input | 1 | Memory fault for the pending request |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write address |
| rf_wdata_o | output | VLEN | Register file write data |
| done_o | output | 1 | Operation finished (one-cycle pulse) |
| fault_o | output | 1 | Operation ended by a fault; valid with done_o |

## Verification
A slot counter that is wrong shows up at once at the port. Either the request address breaks the +4 sequence on the next accepted word, or a word lands in the wrong element or register and is only seen in the four writes at the end. A predicate bit taken from the wrong position shows up as a request that should not be there, or a missing one, on the first affected structure, and also as a nonzero element where zero is expected. Faults that leak into the write phase, and writes that overlap reads, are caught on the cycle where they happen by comparing handshake activity with `done_o` and `fault_o`.

// File: rtl/d4l_pkg.sv
package d4l_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NDST   = 4;
  localparam int unsigned ADDR_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_WRITE,
    ST_DONE,
    ST_FAULT
  } d4l_state_e;
endpackage

// File: rtl/d4l_addr_gen.sv
module d4l_addr_gen #(
  parameter int unsigned AW       = 64,
  parameter int unsigned SCALE_SH = 2,
  parameter int unsigned STEP     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load | adv;
    if (load) addr_d = base_i + (index_i << SCALE_SH);
    else      addr_d = addr_q + AW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/d4l_collect.sv
module d4l_collect #(
  parameter int unsigned ELEMS = 4,
  parameter int unsigned SW    = 4,
  localparam int unsigned VW   = ELEMS * d4l_pkg::WORD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SW-1:0]             slot,
  input  logic [d4l_pkg::WORD_W-1:0] wdata,
  input  logic [1:0]                rd_sel,
  output logic [VW-1:0]             rd_vec
);
  import d4l_pkg::*;

  logic [NDST-1:0][VW-1:0] rows;

  for (genvar r = 0; r < NDST; r++) begin : g_row
    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
      logic [WORD_W-1:0] w_q;
      logic              w_en;
      assign w_en = wr_en && (slot == SW'(e * NDST + r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w_q <= '0;
        else if (w_en) w_q <= wdata;
      end
      assign rows[r][e*WORD_W +: WORD_W] = w_q;
    end
  end

  assign rd_vec = rows[rd_sel];
endmodule

// File: rtl/d4l_ctrl.sv
module d4l_ctrl #(
  parameter int unsigned ELEMS = 4,
  parameter int unsigned SW    = 4,
  parameter int unsigned PL    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          base_is_sp,
  input  logic [3:0]    base_lo,
  input  logic [PL-1:0] pred_i,
  input  logic          sp_chk_none,
  input  logic          mem_rvalid,
  input  logic          mem_fault,
  output logic          load,
  output logic          adv,
  output logic          col_we,
  output logic          col_zero,
  output logic [SW-1:0] slot,
  output logic          mem_req,
  output logic          rf_we,
  output logic [1:0]    wsel,
  output logic          done,
  output logic          fault
);
  import d4l_pkg::*;

  localparam logic [SW-1:0] LAST_SLOT = SW'(ELEMS * NDST - 1);

  d4l_state_e       state_q, state_d;
  logic [SW-1:0]    slot_q, slot_d;
  logic [1:0]       wcnt_q, wcnt_d;
  logic [ELEMS-1:0] act_q, act_d;
  logic             any_act, misalign, cur_act, step;

  for (genvar e = 0; e < ELEMS; e++) begin : g_act
    assign act_d[e] = pred_i[NDST*e];
  end

  always_comb begin
    any_act  = |act_d;
    misalign = base_is_sp && (base_lo != 4'd0) && (any_act || sp_chk_none);
    cur_act  = act_q[slot_q[SW-1:2]];
  end

  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    wcnt_d   = wcnt_q;
    load     = 1'b0;
    adv      = 1'b0;
    col_we   = 1'b0;
    col_zero = 1'b0;
    mem_req  = 1'b0;
    rf_we    = 1'b0;
    done     = 1'b0;
    fault    = 1'b0;
    step     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          slot_d  = '0;
          state_d = misalign ? ST_FAULT : ST_RUN;
        end
      end
      ST_RUN: begin
        if (cur_act) begin
          mem_req = 1'b1;
          if (mem_fault)       state_d = ST_FAULT;
          else if (mem_rvalid) step = 1'b1;
        end else begin
          col_zero = 1'b1;
          step     = 1'b1;
        end
        if (step) begin
          col_we = 1'b1;
          adv    = 1'b1;
          if (slot_q == LAST_SLOT) begin
            state_d = ST_WRITE;
            wcnt_d  = 2'd0;
          end else begin
            slot_d = slot_q + SW'(1);
          end
        end
      end
      ST_WRITE: begin
        rf_we = 1'b1;
        if (wcnt_q == 2'd3) state_d = ST_DONE;
        else                wcnt_d  = wcnt_q + 2'd1;
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FAULT: begin
        done    = 1'b1;
        fault   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      wcnt_q  <= wcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (load) act_q <= act_d;
  end

  assign slot = slot_q;
  assign wsel = wcnt_q;
endmodule

// File: rtl/deint4_load.sv
module deint4_load #(
  parameter int unsigned VLEN = 128,
  localparam int unsigned ELEMS = VLEN / 32,
  localparam int unsigned PL    = VLEN / 8,
  localparam int unsigned SW    = $clog2(ELEMS * 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [63:0]     base_i,
  input  logic [63:0]     index_i,
  input  logic            base_is_sp_i,
  input  logic [PL-1:0]   pred_i,
  input  logic [4:0]      dst_i,
  input  logic            sp_chk_none_i,
  output logic            mem_req_o,
  output logic [63:0]     mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [31:0]     mem_rdata_i,
  input  logic            mem_fault_i,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [VLEN-1:0] rf_wdata_o,
  output logic            done_o,
  output logic            fault_o
);
  import d4l_pkg::*;

  logic          load, adv, col_we, col_zero;
  logic [SW-1:0] slot;
  logic [1:0]    wsel;
  logic [4:0]    dst_q;
  logic [31:0]   col_wdata;

  d4l_ctrl #(.ELEMS(ELEMS), .SW(SW), .PL(PL)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_i),
    .base_is_sp  (base_is_sp_i),
    .base_lo     (base_i[3:0]),
    .pred_i      (pred_i),
    .sp_chk_none (sp_chk_none_i),
    .mem_rvalid  (mem_rvalid_i),
    .mem_fault   (mem_fault_i),
    .load        (load),
    .adv         (adv),
    .col_we      (col_we),
    .col_zero    (col_zero),
    .slot        (slot),
    .mem_req     (mem_req_o),
    .rf_we       (rf_we_o),
    .wsel        (wsel),
    .done        (done_o),
    .fault       (fault_o)
  );

  d4l_addr_gen #(.AW(ADDR_W), .SCALE_SH(2), .STEP(4)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (adv),
    .base_i  (base_i),
    .index_i (index_i),
    .addr_o  (mem_addr_o)
  );

  assign col_wdata = col_zero ? 32'd0 : mem_rdata_i;

  d4l_collect #(.ELEMS(ELEMS), .SW(SW)) u_coll (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (col_we),
    .slot   (slot),
    .wdata  (col_wdata),
    .rd_sel (wsel),
    .rd_vec (rf_wdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dst_q <= '0;
    else if (load) dst_q <= dst_i;
  end

  assign rf_waddr_o = dst_q + {3'b000, wsel};
endmodule

// File: rtl/d4l_checker.sv
module d4l_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_o,
  input logic [63:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        mem_fault_i,
  input logic        rf_we_o,
  input logic        done_o,
  input logic        fault_o
);
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i && !mem_fault_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rvalid_i && !mem_fault_i) |=>
      (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + 64'd4)));

  p_fault_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_fault_i) |=> (done_o && fault_o && !rf_we_o && !mem_req_o));

  p_fault_has_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> done_o);

  p_write_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (!mem_req_o && !done_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_write_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && !$past(rf_we_o)) |=> (rf_we_o ##1 rf_we_o ##1 rf_we_o ##1 (done_o && !fault_o)));
endmodule

bind deint4_load d4l_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_fault_i  (mem_fault_i),
  .rf_we_o      (rf_we_o),
  .done_o       (done_o),
  .fault_o      (fault_o)
);

// File: tb/tb_deint4_load.sv
module tb_deint4_load;
  localparam int VLEN  = 128;
  localparam int ELEMS = VLEN / 32;
  localparam int SLOTS = ELEMS * 4;

  typedef struct packed {
    logic [63:0] base;
    logic [63:0] index;
    logic        sp;
    logic [15:0] pred;
    logic [4:0]  dst;
    logic        chk;
    logic [1:0]  lat;
    logic        xfault;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{64'h1000, 64'h3, 1'b0, 16'hFFFF, 5'd2, 1'b0, 2'd0, 1'b0},                // R2 R3 R4
    '{64'h0000_0001_2000_0000, 64'h0, 1'b0, 16'h1111, 5'd7, 1'b0, 2'd1, 1'b0}, // R3 latency
    '{64'h4000, 64'h10, 1'b0, 16'h0101, 5'd30, 1'b0, 2'd2, 1'b0},              // R5 R7
    '{64'h5000, 64'h1, 1'b0, 16'hEEEE, 5'd0, 1'b0, 2'd0, 1'b0},                // R6
    '{64'h6008, 64'h0, 1'b1, 16'h0010, 5'd4, 1'b0, 2'd0, 1'b1},                // R9
    '{64'h6008, 64'h0, 1'b1, 16'h0000, 5'd9, 1'b0, 2'd0, 1'b0},                // R10 no check
    '{64'h6008, 64'h0, 1'b1, 16'h0000, 5'd9, 1'b1, 2'd0, 1'b1},                // R10 check
    '{64'hFFFF_FFFF_FFFF_FFF0, 64'h1, 1'b1, 16'h1000, 5'd29, 1'b0, 2'd1, 1'b0} // R2 wrap, R7
  };

  logic            clk, rst_n, start_i, base_is_sp_i, sp_chk_none_i;
  logic [63:0]     base_i, index_i;
  logic [15:0]     pred_i;
  logic [4:0]      dst_i;
  logic            mem_req_o, mem_rvalid_i, mem_fault_i;
  logic [63:0]     mem_addr_o;
  logic [31:0]     mem_rdata_i;
  logic            rf_we_o, done_o, fault_o;
  logic [4:0]      rf_waddr_o;
  logic [VLEN-1:0] rf_wdata_o;

  int n_chk  = 0;
  int n_fail = 0;

  deint4_load #(.VLEN(VLEN)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .index_i(index_i),
    .base_is_sp_i(base_is_sp_i), .pred_i(pred_i), .dst_i(dst_i), .sp_chk_none_i(sp_chk_none_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .mem_fault_i(mem_fault_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .done_o(done_o), .fault_o(fault_o)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  function automatic logic [31:0] memf(input logic [63:0] a);
    return a[31:0] ^ 32'h9E37_79B9;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v, input int fault_at, input bit poke);
    logic [63:0]     a0;
    logic [63:0]     exp_addr [SLOTS];
    logic [63:0]     got_addr [SLOTS];
    logic [VLEN-1:0] exp_vec  [4];
    logic [4:0]      got_wa   [4];
    logic [VLEN-1:0] got_wd   [4];
    int              got_wc   [4];
    int nexp, nreq, nw, wc, cyc, done_cyc;
    bit fin, got_fault, xf, addr_ok;
    a0   = v.base + (v.index << 2);
    nexp = 0;
    for (int r = 0; r < 4; r++) exp_vec[r] = '0;
    for (int e = 0; e < ELEMS; e++)
      for (int r = 0; r < 4; r++)
        if (v.pred[4*e]) begin
          exp_addr[nexp] = a0 + 64'(16*e + 4*r);
          nexp++;
          exp_vec[r][32*e +: 32] = memf(a0 + 64'(16*e + 4*r));
        end
    xf = v.xfault || (fault_at >= 0);
    if (v.xfault) nexp = 0;
    if (fault_at >= 0) nexp = fault_at + 1;
    @(negedge clk);
    base_i = v.base; index_i = v.index; base_is_sp_i = v.sp; pred_i = v.pred;
    dst_i = v.dst; sp_chk_none_i = v.chk; start_i = 1'b1;
    nreq = 0; nw = 0; wc = 0; cyc = 0; fin = 0; got_fault = 0; done_cyc = 0;
    while (!fin && cyc < 400) begin
      @(negedge clk);
      cyc++;
      start_i = poke && (cyc == 3);
      if (poke && cyc == 3) begin
        base_i = 64'h7777_0000; pred_i = 16'h0000; dst_i = 5'd20;
      end
      mem_rvalid_i = 1'b0;
      mem_fault_i  = 1'b0;
      if (rf_we_o && nw < 4) begin
        got_wa[nw] = rf_waddr_o; got_wd[nw] = rf_wdata_o; got_wc[nw] = cyc; nw++;
      end
      if (done_o) begin
        fin = 1; got_fault = fault_o; done_cyc = cyc;
      end else if (mem_req_o) begin
        if (wc == int'(v.lat)) begin
          wc = 0;
          if (nreq < SLOTS) got_addr[nreq] = mem_addr_o;
          if (nreq == fault_at) mem_fault_i = 1'b1;
          else begin
            mem_rvalid_i = 1'b1;
            mem_rdata_i  = memf(mem_addr_o);
          end
          nreq++;
        end else wc++;
      end
    end
    start_i = 1'b0;
    // R8: operation finishes (watchdog on a hung operation)
    check(fin, "R8 done seen", 128'(fin), 128'd1);
    // R9 R10 R11: fault flag
    check(got_fault == xf, "R9/R10/R11 fault flag", 128'(got_fault), 128'(xf));
    // R5: number of reads
    check(nreq == nexp, "R5 request count", 128'(nreq), 128'(nexp));
    if (nexp > 0 && nreq > 0)
      check(got_addr[0] == exp_addr[0], "R2 first address", 128'(got_addr[0]), 128'(exp_addr[0]));
    addr_ok = 1;
    for (int i = 0; i < nexp && i < nreq && i < SLOTS; i++)
      if (got_addr[i] != exp_addr[i]) addr_ok = 0;
    check(addr_ok, "R3 address sequence", 128'(addr_ok), 128'd1);
    if (xf) begin
      check(nw == 0, "R11 no writes on fault", 128'(nw), 128'd0);
    end else begin
      check(nw == 4, "R8 write count", 128'(nw), 128'd4);
      if (nw == 4) begin
        check(got_wc[1] == got_wc[0] + 1 && got_wc[2] == got_wc[0] + 2 &&
              got_wc[3] == got_wc[0] + 3 && done_cyc == got_wc[0] + 4,
              "R8 write timing", 128'(done_cyc - got_wc[0]), 128'd4);
        for (int r = 0; r < 4; r++) begin
          check(got_wa[r] == 5'(v.dst + 5'(r)), "R7 write register",
                128'(got_wa[r]), 128'(5'(v.dst + 5'(r))));
          check(got_wd[r] == exp_vec[r], "R4 write data", got_wd[r], exp_vec[r]);
        end
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; base_i = '0; index_i = '0; base_is_sp_i = 1'b0;
    pred_i = '0; dst_i = '0; sp_chk_none_i = 1'b0;
    mem_rvalid_i = 1'b0; mem_fault_i = 1'b0; mem_rdata_i = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    check(!mem_req_o && !rf_we_o && !done_o && !fault_o, "R1 reset outputs",
          128'({mem_req_o, rf_we_o, done_o, fault_o}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req_o && !rf_we_o && !done_o && !fault_o, "R1 after release",
          128'({mem_req_o, rf_we_o, done_o, fault_o}), 128'd0);

    for (int i = 0; i < NVEC; i++) run_op(VECS[i], -1, 1'b0);

    // R11: memory fault on the third read
    run_op(VECS[0], 2, 1'b0);
    // R12: a start pulse during an operation is ignored
    run_op(VECS[0], -1, 1'b1);
    // R6: mixed non-strided bits, only elements 2 and 3 enabled
    run_op('{64'h8000, 64'h2, 1'b0, 16'hFFEE, 5'd31, 1'b0, 2'd0, 1'b0}, -1, 1'b0);

    // R1: reset in the middle of an operation
    @(negedge clk);
    base_i = 64'h9000; index_i = '0; base_is_sp_i = 1'b0; pred_i = 16'hFFFF;
    dst_i = 5'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!mem_req_o && !rf_we_o && !done_o && !fault_o, "R1 mid-op reset",
          128'({mem_req_o, rf_we_o, done_o, fault_o}), 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_req_o && !done_o, "R1 idle after reset",
          128'({mem_req_o, done_o}), 128'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule